// File: doc/BRIEF.md
# Delayed Transmit/Receive Switch Controller

This block turns a transmit-activity input into the two control lines of an antenna switch: a transmit-enable flag and its complement, a receive-enable flag. The switch does not follow activity right away. Each change waits a programmable number of clock cycles, so that it can be lined up with the latency of the transmit datapath that feeds the antenna. Switching into transmit and switching back to receive each have their own delay. A delay can therefore cover the pipeline lead-in, and a separate delay can cover the pipeline drain.

Both delays are loaded at run time through a plain register-write port. The port has a 7-bit address, a 32-bit data word and a one-cycle write strobe. The into-transmit delay lives at address 2 and the back-to-receive delay at address 3. Only the low 12 bits of each written word are kept. A four-state controller (idle in receive, waiting to transmit, transmitting, waiting to return to receive) counts the loaded delay down. The controller drops a pending change at once if activity reverses before the wait is over.

Top module: `atr_switch_delay`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `tx_en` to 0 and `rx_en` to 1 after that edge, cancels any pending wait, and clears both delay registers to 0.
- R2: `rx_en` is always the complement of `tx_en`, and both change only at a rising clock edge.
- R3: With the into-transmit delay set to D, and `tx_active` held high, `tx_en` rises exactly D clock edges after the first edge that samples `tx_active` high in the receive state.
- R4: With the back-to-receive delay set to E, and `tx_active` held low, `tx_en` falls exactly E clock edges after the first edge that samples `tx_active` low in the transmit state.
- R5: A write to address 2 changes only the into-transmit delay, and a write to address 3 changes only the back-to-receive delay.
- R6: A register is written only at a clock edge where `wr_stb` is 1 and all 7 bits of `wr_addr` match. Writes without the strobe, and writes to any other address (including one that differs only in bit 6), leave both delays unchanged.
- R7: Only bits 11:0 of `wr_data` are stored. Bits 31:12 are ignored.
- R8: If `tx_active` is sampled low while the controller is waiting to enter transmit, it returns to the receive state at that edge. `tx_en` never rises for that attempt, and the next attempt waits the full delay again.
- R9: If `tx_active` is sampled high while the controller is waiting to return to receive, it returns to the transmit state at that edge. `tx_en` never falls for that attempt, and the next return waits the full delay again.
- R10: A delay of 0 switches the output at the very edge that first samples the activity change, with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 7 | Register write address (2: into-transmit delay, 3: back-to-receive delay) |
| wr_data | input | 32 | Register write data; bits 11:0 are kept |
| tx_active | input | 1 | Transmit activity from the datapath |
| tx_en | output | 1 | Registered transmit enable to the antenna switch |
| rx_en | output | 1 | Registered receive enable, complement of `tx_en` |

## Verification
The hardest situations to reach from the ports are the two aborted waits. The activity input has to reverse while a countdown is in progress, and no output shows that a countdown has started. The bench programs a delay large enough to leave room, raises or drops `tx_active` on a known edge, and reverses it a counted number of edges later, well inside the window. It then checks that the output never moved. A following full transition confirms that the countdown was reloaded from scratch and not resumed.

// File: rtl/atrd_pkg.sv
package atrd_pkg;

   // Controller states; the output is high in the two states where the
   // antenna faces the transmitter.
   typedef enum logic [1:0] {
      ST_RX_IDLE = 2'd0,
      ST_TX_WAIT = 2'd1,
      ST_TX_LIVE = 2'd2,
      ST_RX_WAIT = 2'd3
   } atrd_state_e;

   // Default register addresses of the two delay values
   localparam int unsigned ATRD_TX_DLY_ADDR = 2;
   localparam int unsigned ATRD_RX_DLY_ADDR = 3;

   // Number of delay registers (into transmit, back to receive)
   localparam int unsigned ATRD_NUM_DLY = 2;

   function automatic logic atrd_faces_tx(input atrd_state_e s);
      return (s == ST_TX_LIVE) || (s == ST_RX_WAIT);
   endfunction

endpackage

// File: rtl/atrd_regs.sv
module atrd_regs #(
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DLY_W   = 12,
   parameter int unsigned TX_ADDR = atrd_pkg::ATRD_TX_DLY_ADDR,
   parameter int unsigned RX_ADDR = atrd_pkg::ATRD_RX_DLY_ADDR
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DLY_W-1:0]  tx_dly,
   output logic [DLY_W-1:0]  rx_dly
);
   import atrd_pkg::*;

   localparam int unsigned NREG = ATRD_NUM_DLY;

   logic [DLY_W-1:0] dly_q [NREG];

   for (genvar gi = 0; gi < NREG; gi++) begin : g_dly
      localparam int unsigned REG_ADDR = (gi == 0) ? TX_ADDR : RX_ADDR;
      localparam logic [ADDR_W-1:0] MATCH = REG_ADDR[ADDR_W-1:0];

      logic hit;
      assign hit = wr_stb && (wr_addr == MATCH);

      always_ff @(posedge clk) begin
         if (rst) begin
            dly_q[gi] <= '0;
         end else if (hit) begin
            dly_q[gi] <= wr_data[DLY_W-1:0];
         end
      end
   end

   assign tx_dly = dly_q[0];
   assign rx_dly = dly_q[1];

endmodule

// File: rtl/atrd_fsm.sv
module atrd_fsm #(
   parameter int unsigned DLY_W = 12
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  tx_active,
   input  logic [DLY_W-1:0]      tx_dly,
   input  logic [DLY_W-1:0]      rx_dly,
   output atrd_pkg::atrd_state_e state,
   output atrd_pkg::atrd_state_e state_nxt
);
   import atrd_pkg::*;

   localparam logic [DLY_W-1:0] ZERO = '0;
   localparam logic [DLY_W-1:0] ONE  = {{(DLY_W-1){1'b0}}, 1'b1};

   atrd_state_e      state_q;
   atrd_state_e      nxt;
   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] cnt_nxt;
   logic             cnt_done;

   assign cnt_done = (cnt_q == ZERO);

   always_comb begin
      nxt     = state_q;
      cnt_nxt = cnt_q;
      unique case (state_q)
         ST_RX_IDLE: begin
            if (tx_active) begin
               if (tx_dly == ZERO) begin
                  nxt = ST_TX_LIVE;
               end else begin
                  nxt     = ST_TX_WAIT;
                  cnt_nxt = tx_dly - ONE;
               end
            end
         end
         ST_TX_WAIT: begin
            if (!tx_active) begin
               nxt     = ST_RX_IDLE;
               cnt_nxt = ZERO;
            end else if (cnt_done) begin
               nxt = ST_TX_LIVE;
            end else begin
               cnt_nxt = cnt_q - ONE;
            end
         end
         ST_TX_LIVE: begin
            if (!tx_active) begin
               if (rx_dly == ZERO) begin
                  nxt = ST_RX_IDLE;
               end else begin
                  nxt     = ST_RX_WAIT;
                  cnt_nxt = rx_dly - ONE;
               end
            end
         end
         ST_RX_WAIT: begin
            if (tx_active) begin
               nxt     = ST_TX_LIVE;
               cnt_nxt = ZERO;
            end else if (cnt_done) begin
               nxt = ST_RX_IDLE;
            end else begin
               cnt_nxt = cnt_q - ONE;
            end
         end
         default: begin
            nxt     = ST_RX_IDLE;
            cnt_nxt = ZERO;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_RX_IDLE;
         cnt_q   <= ZERO;
      end else begin
         state_q <= nxt;
         cnt_q   <= cnt_nxt;
      end
   end

   assign state     = state_q;
   assign state_nxt = nxt;

endmodule

// File: rtl/atrd_out.sv
module atrd_out (
   input  logic                  clk,
   input  logic                  rst,
   input  atrd_pkg::atrd_state_e state_nxt,
   output logic                  tx_en,
   output logic                  rx_en
);
   import atrd_pkg::*;

   logic tx_q;
   logic rx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_q <= 1'b0;
         rx_q <= 1'b1;
      end else begin
         tx_q <= atrd_faces_tx(state_nxt);
         rx_q <= !atrd_faces_tx(state_nxt);
      end
   end

   assign tx_en = tx_q;
   assign rx_en = rx_q;

endmodule

// File: rtl/atr_switch_delay.sv
module atr_switch_delay #(
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DLY_W   = 12,
   parameter int unsigned TX_ADDR = atrd_pkg::ATRD_TX_DLY_ADDR,
   parameter int unsigned RX_ADDR = atrd_pkg::ATRD_RX_DLY_ADDR
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic [6:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              tx_active,
   output logic              tx_en,
   output logic              rx_en
);
   import atrd_pkg::*;

   // Elaboration-time parameter checks
   if (ADDR_W != 7) begin : g_bad_addr_w
      $error("atr_switch_delay: ADDR_W must match the 7-bit address port");
   end
   if (DATA_W != 32) begin : g_bad_data_w
      $error("atr_switch_delay: DATA_W must match the 32-bit data port");
   end
   if (DLY_W < 1 || DLY_W > DATA_W) begin : g_bad_dly_w
      $error("atr_switch_delay: DLY_W must lie in 1..DATA_W");
   end
   if (TX_ADDR == RX_ADDR) begin : g_bad_addr_eq
      $error("atr_switch_delay: delay registers need distinct addresses");
   end
   if (TX_ADDR >= (1 << ADDR_W) || RX_ADDR >= (1 << ADDR_W)) begin : g_bad_addr_rng
      $error("atr_switch_delay: register address outside the address space");
   end

   logic [DLY_W-1:0] tx_dly_val;
   logic [DLY_W-1:0] rx_dly_val;
   atrd_state_e      fsm_state;
   atrd_state_e      fsm_state_nxt;

   atrd_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DLY_W  (DLY_W),
      .TX_ADDR(TX_ADDR),
      .RX_ADDR(RX_ADDR)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr_stb (wr_stb),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .tx_dly (tx_dly_val),
      .rx_dly (rx_dly_val)
   );

   atrd_fsm #(
      .DLY_W(DLY_W)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .tx_active(tx_active),
      .tx_dly   (tx_dly_val),
      .rx_dly   (rx_dly_val),
      .state    (fsm_state),
      .state_nxt(fsm_state_nxt)
   );

   atrd_out u_out (
      .clk      (clk),
      .rst      (rst),
      .state_nxt(fsm_state_nxt),
      .tx_en    (tx_en),
      .rx_en    (rx_en)
   );

endmodule

// File: rtl/atr_switch_delay_chk.sv
module atr_switch_delay_chk #(
   parameter int unsigned DLY_W = 12
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  tx_active,
   input logic                  tx_en,
   input logic                  rx_en,
   input atrd_pkg::atrd_state_e state,
   input logic [DLY_W-1:0]      tx_dly,
   input logic [DLY_W-1:0]      rx_dly
);
   import atrd_pkg::*;

   AST_RESET_SAFE: assert property (@(posedge clk)
      rst |=> (!tx_en && rx_en));                                        // R1

   AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
      rx_en == !tx_en);                                                  // R2

   AST_TX_NEEDS_ACTIVITY: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_en) |-> $past(tx_active));                                // R3

   AST_RX_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
      $fell(tx_en) |-> !$past(tx_active));                               // R4

   AST_TX_WAIT_ABORT: assert property (@(posedge clk) disable iff (rst)
      (state == ST_TX_WAIT && !tx_active) |=> !tx_en);                   // R8

   AST_RX_WAIT_ABORT: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RX_WAIT && tx_active) |=> tx_en);                     // R9

   AST_ZERO_TX_DLY: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RX_IDLE && tx_active && tx_dly == '0) |=> tx_en);     // R10

   AST_ZERO_RX_DLY: assert property (@(posedge clk) disable iff (rst)
      (state == ST_TX_LIVE && !tx_active && rx_dly == '0) |=> !tx_en);   // R10

endmodule

bind atr_switch_delay atr_switch_delay_chk #(
   .DLY_W(DLY_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .tx_active(tx_active),
   .tx_en    (tx_en),
   .rx_en    (rx_en),
   .state    (fsm_state),
   .tx_dly   (tx_dly_val),
   .rx_dly   (rx_dly_val)
);

// File: tb/atr_switch_delay_bench.sv
`timescale 1ns/1ps
module atr_switch_delay_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_stb;
   logic [6:0]  wr_addr;
   logic [31:0] wr_data;
   logic        tx_active;
   logic        tx_en;
   logic        rx_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   atr_switch_delay u_atr_switch_delay (
      .clk      (clk),
      .rst      (rst),
      .wr_stb   (wr_stb),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .tx_active(tx_active),
      .tx_en    (tx_en),
      .rx_en    (rx_en)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // Sample both outputs; rx_en must be the complement (R2)
   task automatic chk_out(input logic exp_tx, input string req);
      chk(tx_en, exp_tx, req);
      chk(rx_en, !exp_tx, "R2 complement");
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic stb);
      @(negedge clk);
      wr_stb  = stb;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   // Raise activity, expect tx_en to rise exactly d edges after the first sampling edge
   task automatic go_tx(input int d, input string req);
      @(negedge clk);
      tx_active = 1'b1;
      for (int i = 0; i < d; i++) begin
         @(negedge clk);
         chk_out(1'b0, req);
      end
      @(negedge clk);
      chk_out(1'b1, req);
   endtask

   task automatic go_rx(input int d, input string req);
      @(negedge clk);
      tx_active = 1'b0;
      for (int i = 0; i < d; i++) begin
         @(negedge clk);
         chk_out(1'b1, req);
      end
      @(negedge clk);
      chk_out(1'b0, req);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk_out(1'b0, "R1 reset state");
      rst = 1'b0;
      @(negedge clk);
      chk_out(1'b0, "R1 idle after reset");
   endtask

   task automatic t_zero_after_reset;
      go_tx(0, "R10 R1 zero tx delay after reset");
      go_rx(0, "R10 R1 zero rx delay after reset");
   endtask

   task automatic t_basic_delays;
      wr(7'd2, 32'd3, 1'b1);
      wr(7'd3, 32'd5, 1'b1);
      go_tx(3, "R3 R5 tx delay 3");
      go_rx(5, "R4 R5 rx delay 5");
   endtask

   task automatic t_low_bits;
      wr(7'd2, 32'hFFFF_F002, 1'b1);
      go_tx(2, "R7 upper bits ignored tx");
      go_rx(5, "R5 rx delay kept");
   endtask

   task automatic t_ignored_writes;
      wr(7'd2, 32'd9, 1'b0);
      wr(7'd4, 32'd9, 1'b1);
      wr(7'h42, 32'd9, 1'b1);
      wr(7'h43, 32'd9, 1'b1);
      go_tx(2, "R6 ignored writes tx");
      go_rx(5, "R6 ignored writes rx");
   endtask

   task automatic t_abort_tx;
      wr(7'd2, 32'd6, 1'b1);
      @(negedge clk);
      tx_active = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk_out(1'b0, "R8 waiting");
      end
      tx_active = 1'b0;
      repeat (9) begin
         @(negedge clk);
         chk_out(1'b0, "R8 aborted tx stays off");
      end
      go_tx(6, "R8 full tx delay after abort");
   endtask

   task automatic t_abort_rx;
      @(negedge clk);
      tx_active = 1'b0;
      repeat (2) begin
         @(negedge clk);
         chk_out(1'b1, "R9 waiting");
      end
      tx_active = 1'b1;
      repeat (8) begin
         @(negedge clk);
         chk_out(1'b1, "R9 aborted rx stays tx");
      end
      go_rx(5, "R9 full rx delay after abort");
   endtask

   task automatic t_reset_mid_wait;
      @(negedge clk);
      tx_active = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk_out(1'b0, "R1 reset cancels wait");
      rst = 1'b0;
      @(negedge clk);
      chk_out(1'b1, "R1 delays cleared by reset");
      go_rx(0, "R1 rx delay cleared by reset");
   endtask

   initial begin
      rst       = 1'b1;
      wr_stb    = 1'b0;
      wr_addr   = '0;
      wr_data   = '0;
      tx_active = 1'b0;
      t_reset();
      t_zero_after_reset();
      t_basic_delays();
      t_low_bits();
      t_ignored_writes();
      t_abort_tx();
      t_abort_rx();
      t_reset_mid_wait();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule